// File: doc/BRIEF.md
# Integer Execute Unit with Register File and Multiply Pair

This block executes one 32-bit integer instruction per clock from a fixed subset of a classic three-operand load/store encoding. An instruction offered with `issue_valid` high is decoded, its source operands are read from an internal 32-entry register file, and the result is computed. On the next rising edge the result is written back to the register file and also appears on a registered write-back port. That port carries the data, the destination index, a write strobe and an illegal-instruction flag.

The unit covers shifts by a constant amount, register-register arithmetic and logic, signed and unsigned set-less-than, and forms that take a 16-bit immediate. A signed 32x32 multiply fills a 64-bit product pair, high and low, which two move instructions read back into the register file. Entry 0 of the register file is a constant zero. Branches, jumps, memory access and traps are handled elsewhere. Every instruction completes in one cycle, so the instruction issued on the next edge sees the result of the one before it.

Top module: `exu_core`

## Requirements
- R1: After reset, `wb_en`, `wb_idx`, `wb_data` and `bad_instr` are 0, every register reads 0 and the multiply pair holds 0.
- R2: Field positions are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0] and imm [15:0]. With opcode 0x00, funct 0x00, 0x02 and 0x03 shift rt left logically, right logically and right arithmetically by shamt, writing rd.
- R3: With opcode 0x00, funct 0x21 writes rs+rt, 0x23 writes rs-rt, 0x24 writes AND, 0x25 OR, 0x26 XOR and 0x27 NOR of rs and rt into rd, all modulo 2^32.
- R4: With opcode 0x00, funct 0x2a writes 1 to rd when rs < rt as signed values and 0 otherwise; funct 0x2b makes the same comparison unsigned.
- R5: With opcode 0x00, funct 0x18 stores the signed 64-bit product rs*rt in the pair (upper half high, lower half low) with `wb_en` low. Funct 0x10 copies the high half and 0x12 the low half into rd. The pair changes on no other instruction.
- R6: Opcode 0x09 writes rs + sign-extended imm into rt. Opcode 0x0a writes the signed comparison rs < sign-extended imm. Opcode 0x0b writes the unsigned comparison of rs against the sign-extended imm.
- R7: Opcodes 0x0c, 0x0d and 0x0e write rs AND, OR and XOR the zero-extended imm into rt.
- R8: Opcode 0x0f writes imm into bits [31:16] of rt with bits [15:0] zero.
- R9: Register 0 always reads 0. A write addressed to it still shows on the port with `wb_idx` 0 but leaves the register at 0.
- R10: Any other opcode, or opcode 0x00 with any other funct, gives `bad_instr`=1, `wb_en`=0, `wb_idx`=0 and `wb_data`=0 one cycle later, and changes neither registers nor the pair.
- R11: Outputs follow the issuing edge by one cycle. When no write is made, `wb_idx` and `wb_data` are 0. A cycle with `issue_valid` low gives all outputs 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered this cycle |
| issue_word | input | 32 | Instruction word |
| wb_en | output | 1 | A register write was made by the last instruction |
| wb_idx | output | 5 | Destination register index, 0 when no write |
| wb_data | output | DATA_W | Value written, 0 when no write |
| bad_instr | output | 1 | The last instruction was not in the supported set |

## Verification
Register and multiply-pair contents are visible only through later instructions. A wrong register value therefore shows on `wb_data` only when an instruction reads that register, which happens one edge after the faulty write at the earliest. The random mix reuses a small set of registers so that corrupted state is read again within a few instructions. A wrong pair value stays hidden until a move from the pair reads it, so moves are mixed in often, including right after illegal and idle cycles. Decode errors show at once in `wb_en`, `wb_idx` or `bad_instr` on the cycle after issue.

// File: rtl/exu_pkg.sv
package exu_pkg;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned RIDX_W  = 5;
   localparam int unsigned IMM_W   = 16;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_ADDIU   = 6'h09;
   localparam logic [5:0] OPC_SLTI    = 6'h0a;
   localparam logic [5:0] OPC_SLTIU   = 6'h0b;
   localparam logic [5:0] OPC_ANDI    = 6'h0c;
   localparam logic [5:0] OPC_ORI     = 6'h0d;
   localparam logic [5:0] OPC_XORI    = 6'h0e;
   localparam logic [5:0] OPC_LUI     = 6'h0f;

   localparam logic [5:0] FN_SLL  = 6'h00;
   localparam logic [5:0] FN_SRL  = 6'h02;
   localparam logic [5:0] FN_SRA  = 6'h03;
   localparam logic [5:0] FN_MFHI = 6'h10;
   localparam logic [5:0] FN_MFLO = 6'h12;
   localparam logic [5:0] FN_MULT = 6'h18;
   localparam logic [5:0] FN_ADDU = 6'h21;
   localparam logic [5:0] FN_SUBU = 6'h23;
   localparam logic [5:0] FN_AND  = 6'h24;
   localparam logic [5:0] FN_OR   = 6'h25;
   localparam logic [5:0] FN_XOR  = 6'h26;
   localparam logic [5:0] FN_NOR  = 6'h27;
   localparam logic [5:0] FN_SLT  = 6'h2a;
   localparam logic [5:0] FN_SLTU = 6'h2b;

   typedef enum logic [3:0] {
      ALU_SLL, ALU_SRL, ALU_SRA, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
      ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU, ALU_HI, ALU_LO, ALU_LUI
   } alu_op_e;

   typedef enum logic [1:0] {
      OPB_REG, OPB_SEXT, OPB_ZEXT
   } opb_sel_e;

   typedef struct packed {
      alu_op_e            op;
      opb_sel_e           opb;
      logic [RIDX_W-1:0]  src_a;
      logic [RIDX_W-1:0]  src_b;
      logic [RIDX_W-1:0]  dst;
      logic [4:0]         shamt;
      logic [IMM_W-1:0]   imm;
      logic               wr;
      logic               mul;
      logic               bad;
   } dec_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
   import exu_pkg::*;
(
   input  logic               valid,
   input  logic [INSTR_W-1:0] word,
   output dec_t               dec
);

   logic [5:0] opc;
   logic [5:0] fn;

   assign opc = word[31:26];
   assign fn  = word[5:0];

   always_comb begin
      dec       = '0;
      dec.op    = ALU_ADD;
      dec.opb   = OPB_REG;
      dec.src_a = word[25:21];
      dec.src_b = word[20:16];
      dec.shamt = word[10:6];
      dec.imm   = word[15:0];
      if (valid) begin
         if (opc == OPC_SPECIAL) begin
            dec.dst = word[15:11];
            dec.wr  = 1'b1;
            case (fn)
               FN_SLL:  dec.op = ALU_SLL;
               FN_SRL:  dec.op = ALU_SRL;
               FN_SRA:  dec.op = ALU_SRA;
               FN_ADDU: dec.op = ALU_ADD;
               FN_SUBU: dec.op = ALU_SUB;
               FN_AND:  dec.op = ALU_AND;
               FN_OR:   dec.op = ALU_OR;
               FN_XOR:  dec.op = ALU_XOR;
               FN_NOR:  dec.op = ALU_NOR;
               FN_SLT:  dec.op = ALU_SLT;
               FN_SLTU: dec.op = ALU_SLTU;
               FN_MFHI: dec.op = ALU_HI;
               FN_MFLO: dec.op = ALU_LO;
               FN_MULT: begin
                  dec.wr  = 1'b0;
                  dec.mul = 1'b1;
               end
               default: begin
                  dec.wr  = 1'b0;
                  dec.bad = 1'b1;
               end
            endcase
         end else begin
            dec.dst = word[20:16];
            dec.wr  = 1'b1;
            case (opc)
               OPC_ADDIU: begin dec.op = ALU_ADD;  dec.opb = OPB_SEXT; end
               OPC_SLTI:  begin dec.op = ALU_SLT;  dec.opb = OPB_SEXT; end
               OPC_SLTIU: begin dec.op = ALU_SLTU; dec.opb = OPB_SEXT; end
               OPC_ANDI:  begin dec.op = ALU_AND;  dec.opb = OPB_ZEXT; end
               OPC_ORI:   begin dec.op = ALU_OR;   dec.opb = OPB_ZEXT; end
               OPC_XORI:  begin dec.op = ALU_XOR;  dec.opb = OPB_ZEXT; end
               OPC_LUI:   dec.op = ALU_LUI;
               default: begin
                  dec.wr  = 1'b0;
                  dec.bad = 1'b1;
               end
            endcase
         end
         if (!dec.wr) dec.dst = '0;
      end
   end

endmodule

// File: rtl/exu_regfile.sv
module exu_regfile #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ra_idx,
   output logic [DATA_W-1:0] ra_val,
   input  logic [ADDR_W-1:0] rb_idx,
   output logic [DATA_W-1:0] rb_val,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa_idx,
   input  logic [DATA_W-1:0] wa_val
);

   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      if (g == 0) begin : g_zero
         assign ent[g] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (wa_idx == ADDR_W'(g)))
               q <= wa_val;
         end
         assign ent[g] = q;
      end
   end

   assign ra_val = ent[ra_idx];
   assign rb_val = ent[rb_idx];

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  alu_op_e           op,
   input  opb_sel_e          opb,
   input  logic [4:0]        shamt,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b_reg,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   output logic [DATA_W-1:0] res
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] b;
   logic              lt_s;
   logic              lt_u;

   always_comb begin
      case (opb)
         OPB_SEXT: b = {{EXT_W{imm[IMM_W-1]}}, imm};
         OPB_ZEXT: b = {{EXT_W{1'b0}}, imm};
         default:  b = b_reg;
      endcase
   end

   assign lt_s = $signed(a) < $signed(b);
   assign lt_u = a < b;

   always_comb begin
      case (op)
         ALU_SLL:  res = b_reg << shamt;
         ALU_SRL:  res = b_reg >> shamt;
         ALU_SRA:  res = $unsigned($signed(b_reg) >>> shamt);
         ALU_ADD:  res = a + b;
         ALU_SUB:  res = a - b;
         ALU_AND:  res = a & b;
         ALU_OR:   res = a | b;
         ALU_XOR:  res = a ^ b;
         ALU_NOR:  res = ~(a | b);
         ALU_SLT:  res = {{(DATA_W-1){1'b0}}, lt_s};
         ALU_SLTU: res = {{(DATA_W-1){1'b0}}, lt_u};
         ALU_HI:   res = hi;
         ALU_LO:   res = lo;
         ALU_LUI:  res = {{(DATA_W-32){1'b0}}, imm, 16'h0000};
         default:  res = '0;
      endcase
   end

endmodule

// File: rtl/exu_mulpair.sv
module exu_mulpair #(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SIGNED_MUL = 1'b1,
   localparam int unsigned PROD_W    = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] hi,
   output logic [DATA_W-1:0] lo
);

   logic [PROD_W-1:0] prod;

   if (SIGNED_MUL) begin : g_signed
      logic signed [PROD_W-1:0] ax;
      logic signed [PROD_W-1:0] bx;
      assign ax   = {{DATA_W{a[DATA_W-1]}}, a};
      assign bx   = {{DATA_W{b[DATA_W-1]}}, b};
      assign prod = ax * bx;
   end else begin : g_unsigned
      logic [PROD_W-1:0] ax;
      logic [PROD_W-1:0] bx;
      assign ax   = {{DATA_W{1'b0}}, a};
      assign bx   = {{DATA_W{1'b0}}, b};
      assign prod = ax * bx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (fire) begin
         hi <= prod[PROD_W-1:DATA_W];
         lo <= prod[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/exu_core.sv
module exu_core
   import exu_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter bit          SIGNED_MUL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_valid,
   input  logic [31:0]        issue_word,
   output logic               wb_en,
   output logic [4:0]         wb_idx,
   output logic [DATA_W-1:0]  wb_data,
   output logic               bad_instr
);

   if (DATA_W < 32) begin : g_bad_width
      $error("exu_core: DATA_W must be at least 32");
   end

   dec_t              dec;
   logic [RIDX_W-1:0] rs_idx;
   logic [DATA_W-1:0] rs_val;
   logic [DATA_W-1:0] rt_val;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] hi_q;
   logic [DATA_W-1:0] lo_q;
   logic              mul_fire;

   exu_decode u_dec (
      .valid (issue_valid),
      .word  (issue_word),
      .dec   (dec)
   );

   assign rs_idx   = dec.src_a;
   assign mul_fire = dec.mul;

   exu_regfile #(.DATA_W(DATA_W), .ADDR_W(RIDX_W)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra_idx (rs_idx),
      .ra_val (rs_val),
      .rb_idx (dec.src_b),
      .rb_val (rt_val),
      .we     (dec.wr),
      .wa_idx (dec.dst),
      .wa_val (alu_res)
   );

   exu_alu #(.DATA_W(DATA_W)) u_alu (
      .op    (dec.op),
      .opb   (dec.opb),
      .shamt (dec.shamt),
      .imm   (dec.imm),
      .a     (rs_val),
      .b_reg (rt_val),
      .hi    (hi_q),
      .lo    (lo_q),
      .res   (alu_res)
   );

   exu_mulpair #(.DATA_W(DATA_W), .SIGNED_MUL(SIGNED_MUL)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (mul_fire),
      .a     (rs_val),
      .b     (rt_val),
      .hi    (hi_q),
      .lo    (lo_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en     <= 1'b0;
         wb_idx    <= '0;
         wb_data   <= '0;
         bad_instr <= 1'b0;
      end else begin
         wb_en     <= dec.wr;
         wb_idx    <= dec.dst;
         wb_data   <= dec.wr ? alu_res : '0;
         bad_instr <= dec.bad;
      end
   end

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic [31:0]       issue_word,
   input logic              wb_en,
   input logic [4:0]        wb_idx,
   input logic [DATA_W-1:0] wb_data,
   input logic              bad_instr,
   input logic [4:0]        rs_idx,
   input logic [DATA_W-1:0] rs_val,
   input logic              mul_fire,
   input logic [DATA_W-1:0] hi_q,
   input logic [DATA_W-1:0] lo_q
);

   // R10
   bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_instr |-> (!wb_en && wb_idx == 5'd0 && wb_data == '0));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_valid |=> (!wb_en && !bad_instr && wb_data == '0));

   // R5
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mul_fire |=> ($stable(hi_q) && $stable(lo_q)));

   // R9
   zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_idx == 5'd0) |-> (rs_val == '0));

   // R8
   upper_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_word[31:26] == 6'h0f) |=> (wb_en && wb_data[15:0] == 16'h0000));

   // R4
   compare_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_word[31:26] == 6'h00 &&
       (issue_word[5:0] == 6'h2a || issue_word[5:0] == 6'h2b))
      |=> (wb_data[DATA_W-1:1] == '0));

endmodule

bind exu_core exu_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .issue_valid (issue_valid),
   .issue_word  (issue_word),
   .wb_en       (wb_en),
   .wb_idx      (wb_idx),
   .wb_data     (wb_data),
   .bad_instr   (bad_instr),
   .rs_idx      (rs_idx),
   .rs_val      (rs_val),
   .mul_fire    (mul_fire),
   .hi_q        (hi_q),
   .lo_q        (lo_q)
);

// File: tb/sim_exu_core.sv
`timescale 1ns/1ps
module sim_exu_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [31:0] issue_word = '0;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;
   logic        bad_instr;

   int n_chk  = 0;
   int n_fail = 0;

   logic [31:0] mreg [32];
   logic [31:0] mhi;
   logic [31:0] mlo;

   always #2.5 clk = ~clk;

   exu_core u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .issue_word  (issue_word),
      .wb_en       (wb_en),
      .wb_idx      (wb_idx),
      .wb_data     (wb_data),
      .bad_instr   (bad_instr)
   );

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [4:0] rd,
                                         input logic [4:0] sh);
      return {6'h00, rs, rt, rd, sh, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic string tag_of(input logic [31:0] w);
      logic [5:0] op;
      logic [5:0] fn;
      op = w[31:26];
      fn = w[5:0];
      if (op == 6'h00) begin
         case (fn)
            6'h00, 6'h02, 6'h03: return "R2";
            6'h21, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27: return "R3";
            6'h2a, 6'h2b: return "R4";
            6'h10, 6'h12, 6'h18: return "R5";
            default: return "R10";
         endcase
      end
      case (op)
         6'h09, 6'h0a, 6'h0b: return "R6";
         6'h0c, 6'h0d, 6'h0e: return "R7";
         6'h0f: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic model(input logic [31:0] w, output logic e_en, output logic [4:0] e_idx,
                        output logic [31:0] e_dat, output logic e_bad);
      logic [31:0] a, b, sx, zx, r;
      logic signed [63:0] pa, pb, pp;
      logic [4:0] rd;
      a  = mreg[w[25:21]];
      b  = mreg[w[20:16]];
      sx = {{16{w[15]}}, w[15:0]};
      zx = {16'h0, w[15:0]};
      r  = '0;
      e_en = 1'b1;
      e_bad = 1'b0;
      rd = (w[31:26] == 6'h00) ? w[15:11] : w[20:16];
      if (w[31:26] == 6'h00) begin
         case (w[5:0])
            6'h00: r = b << w[10:6];
            6'h02: r = b >> w[10:6];
            6'h03: r = $unsigned($signed(b) >>> w[10:6]);
            6'h21: r = a + b;
            6'h23: r = a - b;
            6'h24: r = a & b;
            6'h25: r = a | b;
            6'h26: r = a ^ b;
            6'h27: r = ~(a | b);
            6'h2a: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6'h2b: r = (a < b) ? 32'd1 : 32'd0;
            6'h10: r = mhi;
            6'h12: r = mlo;
            6'h18: begin
               pa = {{32{a[31]}}, a};
               pb = {{32{b[31]}}, b};
               pp = pa * pb;
               mhi = pp[63:32];
               mlo = pp[31:0];
               e_en = 1'b0;
            end
            default: begin e_en = 1'b0; e_bad = 1'b1; end
         endcase
      end else begin
         case (w[31:26])
            6'h09: r = a + sx;
            6'h0a: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
            6'h0b: r = (a < sx) ? 32'd1 : 32'd0;
            6'h0c: r = a & zx;
            6'h0d: r = a | zx;
            6'h0e: r = a ^ zx;
            6'h0f: r = {w[15:0], 16'h0000};
            default: begin e_en = 1'b0; e_bad = 1'b1; end
         endcase
      end
      if (e_en && rd != 5'd0) mreg[rd] = r;
      e_idx = e_en ? rd : 5'd0;
      e_dat = e_en ? r : 32'd0;
   endtask

   task automatic check(input string tag, input logic e_en, input logic [4:0] e_idx,
                        input logic [31:0] e_dat, input logic e_bad);
      n_chk++;
      if (wb_en !== e_en || wb_idx !== e_idx || wb_data !== e_dat || bad_instr !== e_bad) begin
         n_fail++;
         $display("FAIL %s: got en=%0b idx=%0d data=%h bad=%0b, expected en=%0b idx=%0d data=%h bad=%0b",
                  tag, wb_en, wb_idx, wb_data, bad_instr, e_en, e_idx, e_dat, e_bad);
      end
   endtask

   // Issue at a falling edge, check at the next falling edge.
   task automatic issue(input logic [31:0] w);
      logic e_en, e_bad;
      logic [4:0] e_idx;
      logic [31:0] e_dat;
      issue_valid = 1'b1;
      issue_word  = w;
      model(w, e_en, e_idx, e_dat, e_bad);
      @(negedge clk);
      check(tag_of(w), e_en, e_idx, e_dat, e_bad);
   endtask

   task automatic idle();
      issue_valid = 1'b0;
      issue_word  = $urandom;
      @(negedge clk);
      check("R11", 1'b0, 5'd0, 32'd0, 1'b0);
   endtask

   task automatic load(input logic [4:0] r, input logic [31:0] v);
      issue(enc_i(6'h0f, 5'd0, r, v[31:16]));
      issue(enc_i(6'h0d, r, r, v[15:0]));
   endtask

   function automatic logic [31:0] rand_instr();
      logic [4:0] s, t, d;
      logic [15:0] im;
      int k;
      s  = 5'($urandom_range(0, 7));
      t  = 5'($urandom_range(0, 7));
      d  = 5'($urandom_range(0, 7));
      im = 16'($urandom);
      k  = $urandom_range(0, 23);
      case (k)
         0:  return enc_r(6'h00, s, t, d, 5'($urandom));
         1:  return enc_r(6'h02, s, t, d, 5'($urandom));
         2:  return enc_r(6'h03, s, t, d, 5'($urandom));
         3:  return enc_r(6'h21, s, t, d, 5'd0);
         4:  return enc_r(6'h23, s, t, d, 5'd0);
         5:  return enc_r(6'h24, s, t, d, 5'd0);
         6:  return enc_r(6'h25, s, t, d, 5'd0);
         7:  return enc_r(6'h26, s, t, d, 5'd0);
         8:  return enc_r(6'h27, s, t, d, 5'd0);
         9:  return enc_r(6'h2a, s, t, d, 5'd0);
         10: return enc_r(6'h2b, s, t, d, 5'd0);
         11: return enc_r(6'h18, s, t, 5'd0, 5'd0);
         12: return enc_r(6'h10, 5'd0, 5'd0, d, 5'd0);
         13: return enc_r(6'h12, 5'd0, 5'd0, d, 5'd0);
         14: return enc_i(6'h09, s, t, im);
         15: return enc_i(6'h0a, s, t, im);
         16: return enc_i(6'h0b, s, t, im);
         17: return enc_i(6'h0c, s, t, im);
         18: return enc_i(6'h0d, s, t, im);
         19: return enc_i(6'h0e, s, t, im);
         20: return enc_i(6'h0f, s, t, im);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      for (int i = 0; i < 32; i++) mreg[i] = '0;
      mhi = '0;
      mlo = '0;
      void'($urandom(32'h1c0de5));
      repeat (3) @(negedge clk);
      // R1: outputs zero in reset and just after release
      check("R1", 1'b0, 5'd0, 32'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0, 5'd0, 32'd0, 1'b0);
      // R1: registers and pair start at zero
      issue(enc_r(6'h21, 5'd5, 5'd6, 5'd7, 5'd0));
      issue(enc_r(6'h10, 5'd0, 5'd0, 5'd8, 5'd0));
      issue(enc_r(6'h12, 5'd0, 5'd0, 5'd8, 5'd0));

      load(5'd1, 32'h8000_0000);
      load(5'd2, 32'h7fff_ffff);
      load(5'd3, 32'hffff_ffff);
      load(5'd4, 32'h0000_0001);
      load(5'd5, 32'h1234_5678);
      load(5'd6, 32'hdead_beef);
      load(5'd7, 32'h0000_8000);

      // R2 corners: arithmetic vs logical shift of a negative value
      issue(enc_r(6'h03, 5'd0, 5'd1, 5'd8, 5'd31));
      issue(enc_r(6'h02, 5'd0, 5'd1, 5'd8, 5'd31));
      issue(enc_r(6'h00, 5'd0, 5'd4, 5'd8, 5'd31));
      // R4 corners: signed vs unsigned on the sign bit
      issue(enc_r(6'h2a, 5'd1, 5'd4, 5'd9, 5'd0));
      issue(enc_r(6'h2b, 5'd1, 5'd4, 5'd9, 5'd0));
      // R6: unsigned compare against a sign-extended 0xffff
      issue(enc_i(6'h0b, 5'd2, 5'd9, 16'hffff));
      issue(enc_i(6'h0b, 5'd3, 5'd9, 16'hffff));
      issue(enc_i(6'h0a, 5'd4, 5'd9, 16'hffff));
      issue(enc_i(6'h09, 5'd4, 5'd9, 16'h8000));
      // R7: zero extension
      issue(enc_i(6'h0c, 5'd3, 5'd10, 16'hffff));
      issue(enc_i(6'h0d, 5'd0, 5'd10, 16'h8001));
      // R5: signed product, then read both halves
      issue(enc_r(6'h18, 5'd3, 5'd3, 5'd0, 5'd0));
      issue(enc_r(6'h10, 5'd0, 5'd0, 5'd11, 5'd0));
      issue(enc_r(6'h12, 5'd0, 5'd0, 5'd11, 5'd0));
      issue(enc_r(6'h18, 5'd1, 5'd2, 5'd0, 5'd0));
      issue(enc_r(6'h10, 5'd0, 5'd0, 5'd11, 5'd0));
      // R9: write to register 0 has no lasting effect
      issue(enc_i(6'h09, 5'd0, 5'd0, 16'h0005));
      issue(enc_r(6'h21, 5'd0, 5'd0, 5'd12, 5'd0));
      // R10: illegal codes leave pair and registers alone
      issue(enc_r(6'h01, 5'd3, 5'd3, 5'd5, 5'd0));
      issue(enc_i(6'h02, 5'd3, 5'd5, 16'h1111));
      issue(enc_r(6'h10, 5'd0, 5'd0, 5'd13, 5'd0));
      issue(enc_r(6'h21, 5'd5, 5'd0, 5'd13, 5'd0));
      // R11: idle cycle keeps state
      idle();
      issue(enc_r(6'h12, 5'd0, 5'd0, 5'd14, 5'd0));

      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 15) == 0) idle();
         else issue(rand_instr());
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule